// File: doc/BRIEF.md
# PCI DMA Window Address Translator

This block converts an address seen on the PCI side of a host bridge into a physical memory address for DMA. It holds a small set of programmable windows. Each window has a base register, a size mask register and a translated-base register. An incoming bus address is compared against every window on an 11-bit field, bits 30 to 20, and the size mask excludes some of those bits from the compare. The lowest-numbered enabled window that matches decides the result.

For a direct-mapped window, the translated address keeps the bus-address bits that lie inside the window. These are the low 20 bits plus any field bits the mask opens. All other bits come from the translated-base register. A window flagged for scatter-gather mapping is not translated: the response reports an error, because page-table walks are not part of this block.

Software programs the windows through a plain 64-bit word-addressed register port. A translation request is presented with a valid strobe, and the registered answer appears one clock later with a response valid, a hit flag and an error flag.

Top module: `pdx_xlate`

## Requirements
- R1: After reset, every window register reads zero and the response outputs (`rsp_valid`, `rsp_hit`, `rsp_err`, `rsp_addr`) are zero.
- R2: Register word offsets are fixed as follows. Offsets 0..3 hold window bases 0..3, offsets 4..7 hold masks 0..3, and offsets 8..11 hold translated bases 0..3. A write with `reg_wr` high stores the full 64-bit word at the clock edge, and `reg_rdata` shows the word at `reg_addr` in the same cycle.
- R3: Offsets 12..15 are unmapped. They read zero, and a write to them changes no register.
- R4: A window matches when the bus address and its base agree on every bit of 30..20 where the window's mask bit is zero. Address bits outside 30..20 never affect matching.
- R5: Bit 0 of a base register enables the window. A matching window with bit 0 clear is skipped, and the search moves on to the next window.
- R6: Bit 1 of a base register selects scatter-gather mode. If the deciding window has bit 1 set, the response has `rsp_err`=1, `rsp_hit`=0 and `rsp_addr`=0.
- R7: For a direct-mapped hit, the offset mask is (mask AND bits 30..20) OR 0xFFFFF. The response address is (translated base AND NOT offset mask) OR (bus address AND offset mask), with `rsp_hit`=1 and `rsp_err`=0.
- R8: Windows are searched from index 0 upward, and the first enabled matching window alone decides the response.
- R9: If no enabled window matches, the response has `rsp_addr`=0, `rsp_hit`=0 and `rsp_err`=0.
- R10: `rsp_valid` is high exactly one clock after `req_valid` was high. While `rsp_valid` is low, `rsp_hit`, `rsp_err` and `rsp_addr` are zero.
- R11: A register write in the same cycle as a request does not affect that request. The request is translated with the register values from before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | REG_AW (4) | Register word offset |
| reg_wdata | input | ADDR_W (64) | Register write data |
| reg_rdata | output | ADDR_W (64) | Register read data for `reg_addr` |
| req_valid | input | 1 | Translation request strobe |
| req_addr | input | ADDR_W (64) | PCI bus address to translate |
| rsp_valid | output | 1 | Response valid, one clock after the request |
| rsp_addr | output | ADDR_W (64) | Translated physical address, or zero |
| rsp_hit | output | 1 | A direct-mapped window translated the address |
| rsp_err | output | 1 | The deciding window requires scatter-gather mapping |

## Verification
The assertions assume that `req_valid` and `reg_wr` are known after reset and that `reg_addr` always holds a known offset in 0..15. The bench drives every input on the falling clock edge, so those values stay settled through each rising edge. Random bus addresses are built mostly from a programmed window base, so matching, disabled, scatter-gather and overlapping windows all occur often. Every offset, including the unmapped ones, is chosen from the 4-bit range only. Directed cases cover address bits above 30 being ignored, a mask that opens field bits, and a write that coincides with a request.

// File: rtl/pdx_pkg.sv
package pdx_pkg;
   // register groups, selected by the upper bits of the word offset
   localparam int GRP_BASE  = 0;
   localparam int GRP_MASK  = 1;
   localparam int GRP_XBASE = 2;
   localparam int NUM_GRP   = 3;
endpackage

// File: rtl/pdx_regfile.sv
module pdx_regfile #(
   parameter int NUM_WIN = 4,
   parameter int ADDR_W  = 64,
   parameter int REG_AW  = 4
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr,
   input  logic [REG_AW-1:0] addr,
   input  logic [ADDR_W-1:0] wdata,
   output logic [ADDR_W-1:0] rdata,
   output logic [ADDR_W-1:0] base_o  [NUM_WIN],
   output logic [ADDR_W-1:0] mask_o  [NUM_WIN],
   output logic [ADDR_W-1:0] xbase_o [NUM_WIN]
);
   import pdx_pkg::*;
   localparam int IW = $clog2(NUM_WIN);
   localparam int GW = REG_AW - IW;

   logic [IW-1:0] idx;
   logic [GW-1:0] grp;
   assign idx = addr[IW-1:0];
   assign grp = addr[REG_AW-1:IW];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int i = 0; i < NUM_WIN; i++) begin
            base_o[i]  <= '0;
            mask_o[i]  <= '0;
            xbase_o[i] <= '0;
         end
      end else if (wr) begin
         if (grp == GW'(GRP_BASE))  base_o[idx]  <= wdata;
         if (grp == GW'(GRP_MASK))  mask_o[idx]  <= wdata;
         if (grp == GW'(GRP_XBASE)) xbase_o[idx] <= wdata;
      end
   end

   always_comb begin
      rdata = '0;
      if (grp == GW'(GRP_BASE))  rdata = base_o[idx];
      if (grp == GW'(GRP_MASK))  rdata = mask_o[idx];
      if (grp == GW'(GRP_XBASE)) rdata = xbase_o[idx];
   end
endmodule

// File: rtl/pdx_win_match.sv
module pdx_win_match #(
   parameter int ADDR_W = 64,
   parameter int FLD_LO = 20,
   parameter int FLD_HI = 30
) (
   input  logic [ADDR_W-1:0] addr,
   input  logic [ADDR_W-1:0] base,
   input  logic [ADDR_W-1:0] mask,
   input  logic [ADDR_W-1:0] xbase,
   output logic              sel,
   output logic              sg,
   output logic [ADDR_W-1:0] xaddr
);
   localparam logic [ADDR_W-1:0] ONE     = ADDR_W'(1);
   localparam logic [ADDR_W-1:0] FLD_MSK = (ONE << (FLD_HI + 1)) - (ONE << FLD_LO);
   localparam logic [ADDR_W-1:0] LOW_MSK = (ONE << FLD_LO) - ONE;

   logic [ADDR_W-1:0] cmp_msk, off_msk;
   logic              hit_fld;

   assign cmp_msk = ~mask & FLD_MSK;
   assign hit_fld = ((addr ^ base) & cmp_msk) == '0;
   assign sel     = hit_fld & base[0];
   assign sg      = base[1];
   assign off_msk = (mask & FLD_MSK) | LOW_MSK;
   assign xaddr   = (xbase & ~off_msk) | (addr & off_msk);
endmodule

// File: rtl/pdx_prio_sel.sv
module pdx_prio_sel #(
   parameter int NUM_WIN = 4,
   parameter int ADDR_W  = 64
) (
   input  logic [NUM_WIN-1:0] sel,
   input  logic [NUM_WIN-1:0] sg,
   input  logic [ADDR_W-1:0]  xaddr [NUM_WIN],
   output logic               hit,
   output logic               err,
   output logic [ADDR_W-1:0]  addr
);
   // scan from the top so the lowest selected index is written last
   always_comb begin
      hit  = 1'b0;
      err  = 1'b0;
      addr = '0;
      for (int i = NUM_WIN - 1; i >= 0; i--) begin
         if (sel[i]) begin
            hit  = ~sg[i];
            err  = sg[i];
            addr = sg[i] ? '0 : xaddr[i];
         end
      end
   end
endmodule

// File: rtl/pdx_xlate.sv
module pdx_xlate #(
   parameter int NUM_WIN = 4,
   parameter int ADDR_W  = 64,
   parameter int REG_AW  = 4,
   parameter int FLD_LO  = 20,
   parameter int FLD_HI  = 30
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              reg_wr,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic [ADDR_W-1:0] reg_wdata,
   output logic [ADDR_W-1:0] reg_rdata,
   input  logic              req_valid,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic              rsp_hit,
   output logic              rsp_err
);
   localparam int NUM_REG = pdx_pkg::NUM_GRP * NUM_WIN;

   generate
      if ((1 << $clog2(NUM_WIN)) != NUM_WIN || NUM_WIN < 2)
         $error("NUM_WIN must be a power of two, at least 2");
      if ((1 << REG_AW) < NUM_REG)
         $error("REG_AW too small for the register set");
      if (FLD_HI >= ADDR_W || FLD_LO < 2 || FLD_LO > FLD_HI)
         $error("compare field does not fit the address");
   endgenerate

   logic [ADDR_W-1:0] base_q  [NUM_WIN];
   logic [ADDR_W-1:0] mask_q  [NUM_WIN];
   logic [ADDR_W-1:0] xbase_q [NUM_WIN];
   logic [ADDR_W-1:0] xaddr_w [NUM_WIN];
   logic [NUM_WIN-1:0] sel_w, sg_w;
   logic              hit_d, err_d;
   logic [ADDR_W-1:0] addr_d;

   pdx_regfile #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .REG_AW(REG_AW)) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr),
      .wdata(reg_wdata), .rdata(reg_rdata),
      .base_o(base_q), .mask_o(mask_q), .xbase_o(xbase_q)
   );

   for (genvar w = 0; w < NUM_WIN; w++) begin : g_win
      pdx_win_match #(.ADDR_W(ADDR_W), .FLD_LO(FLD_LO), .FLD_HI(FLD_HI)) u_match (
         .addr(req_addr), .base(base_q[w]), .mask(mask_q[w]), .xbase(xbase_q[w]),
         .sel(sel_w[w]), .sg(sg_w[w]), .xaddr(xaddr_w[w])
      );
   end

   pdx_prio_sel #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W)) u_prio (
      .sel(sel_w), .sg(sg_w), .xaddr(xaddr_w),
      .hit(hit_d), .err(err_d), .addr(addr_d)
   );

   // the request samples the registers before a same-edge write lands
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         rsp_valid <= 1'b0;
         rsp_hit   <= 1'b0;
         rsp_err   <= 1'b0;
         rsp_addr  <= '0;
      end else begin
         rsp_valid <= req_valid;
         rsp_hit   <= req_valid & hit_d;
         rsp_err   <= req_valid & err_d;
         rsp_addr  <= req_valid ? addr_d : '0;
      end
   end
endmodule

// File: rtl/pdx_xlate_chk.sv
module pdx_xlate_chk #(
   parameter int NUM_WIN = 4,
   parameter int ADDR_W  = 64,
   parameter int REG_AW  = 4,
   parameter int FLD_LO  = 20
) (
   input logic              clk,
   input logic              rst_n,
   input logic [REG_AW-1:0] reg_addr,
   input logic [ADDR_W-1:0] reg_rdata,
   input logic              req_valid,
   input logic [ADDR_W-1:0] req_addr,
   input logic              rsp_valid,
   input logic [ADDR_W-1:0] rsp_addr,
   input logic              rsp_hit,
   input logic              rsp_err
);
   localparam logic [ADDR_W-1:0] LOW_MSK = (ADDR_W'(1) << FLD_LO) - ADDR_W'(1);

   a_r10_rsp_follows_req: assert property (@(posedge clk) disable iff (!rst_n)
      req_valid |=> rsp_valid);
   a_r10_no_spurious_rsp: assert property (@(posedge clk) disable iff (!rst_n)
      !req_valid |=> !rsp_valid);
   a_r10_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      !rsp_valid |-> (!rsp_hit && !rsp_err && rsp_addr == '0));
   a_r6_err_excludes_hit: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_err |-> (!rsp_hit && rsp_addr == '0));
   a_r9_miss_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && !rsp_hit) |-> rsp_addr == '0);
   a_r7_offset_kept: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_hit) |-> (rsp_addr & LOW_MSK) == ($past(req_addr) & LOW_MSK));
   a_r3_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
      (int'(reg_addr) >= 3 * NUM_WIN) |-> reg_rdata == '0);
endmodule

bind pdx_xlate pdx_xlate_chk #(.NUM_WIN(NUM_WIN), .ADDR_W(ADDR_W), .REG_AW(REG_AW), .FLD_LO(FLD_LO)) u_chk (
   .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_rdata(reg_rdata),
   .req_valid(req_valid), .req_addr(req_addr), .rsp_valid(rsp_valid),
   .rsp_addr(rsp_addr), .rsp_hit(rsp_hit), .rsp_err(rsp_err)
);

// File: tb/pdx_xlate_bench.sv
module pdx_xlate_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NW = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [3:0]  reg_addr = '0;
   logic [63:0] reg_wdata = '0;
   logic [63:0] reg_rdata;
   logic        req_valid = 1'b0;
   logic [63:0] req_addr = '0;
   logic        rsp_valid, rsp_hit, rsp_err;
   logic [63:0] rsp_addr;

   int checks = 0;
   int fails  = 0;
   logic [63:0] m_reg [12];

   always #(CLK_PERIOD / 2) clk = ~clk;

   pdx_xlate u_pdx_xlate (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .req_valid(req_valid),
      .req_addr(req_addr), .rsp_valid(rsp_valid), .rsp_addr(rsp_addr),
      .rsp_hit(rsp_hit), .rsp_err(rsp_err)
   );

   function automatic void model(input logic [63:0] a, output logic [63:0] xa,
                                 output logic hit, output logic err);
      logic found = 1'b0;
      logic [63:0] fld = 64'h7ff << 20;
      xa = '0; hit = 1'b0; err = 1'b0;
      for (int i = 0; i < NW; i++) begin
         logic [63:0] b = m_reg[i], m = m_reg[4 + i], t = m_reg[8 + i];
         logic [63:0] om = (m & fld) | 64'hfffff;
         if (!found && b[0] && (((a ^ b) & ~m & fld) == 0)) begin
            found = 1'b1;
            if (b[1]) err = 1'b1;
            else begin hit = 1'b1; xa = (t & ~om) | (a & om); end
         end
      end
   endfunction

   task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input logic [3:0] o, input logic [63:0] d);
      @(negedge clk);
      reg_wr = 1'b1; reg_addr = o; reg_wdata = d;
      @(negedge clk);
      reg_wr = 1'b0;
      if (o < 12) m_reg[o] = d;
   endtask

   task automatic reg_check(input string tag, input logic [3:0] o);
      @(negedge clk);
      reg_addr = o;
      #1;
      check(tag, reg_rdata, (o < 12) ? m_reg[o] : 64'h0);
   endtask

   task automatic xlate_check(input string tag, input logic [63:0] a);
      logic [63:0] ea; logic eh, ee;
      model(a, ea, eh, ee);
      @(negedge clk);
      req_valid = 1'b1; req_addr = a;
      @(negedge clk);
      req_valid = 1'b0;
      check({tag, " R10 valid"}, {63'h0, rsp_valid}, 64'h1);
      check({tag, " addr"}, rsp_addr, ea);
      check({tag, " hit/err"}, {62'h0, rsp_hit, rsp_err}, {62'h0, eh, ee});
   endtask

   initial begin
      logic [63:0] ea, a;
      logic eh, ee;
      void'($urandom(32'd1234));
      for (int i = 0; i < 12; i++) m_reg[i] = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1: reset state
      for (int i = 0; i < 12; i++) reg_check("R1 reset reg", 4'(i));
      check("R1 reset rsp", {rsp_valid, rsp_hit, rsp_err} == 3'b000 && rsp_addr == 0, 1);
      // R9: miss with all windows off
      xlate_check("R9 empty miss", 64'h0000_0000_4012_3456);
      // R10: response valid drops after one cycle
      @(negedge clk);
      check("R10 one-shot", {rsp_valid, rsp_hit, rsp_err} == 3'b000 && rsp_addr == 0, 1);
      // R2: all twelve registers
      for (int i = 0; i < 12; i++) reg_write(4'(i), {32'hA5A5_0000 + 32'(i), 32'h1357_9BDF});
      for (int i = 0; i < 12; i++) reg_check("R2 readback", 4'(i));
      // R3: unmapped offsets
      reg_write(4'd13, 64'hDEAD_BEEF_DEAD_BEEF);
      reg_check("R3 unmapped read", 4'd13);
      for (int i = 0; i < 12; i++) reg_check("R3 no side effect", 4'(i));
      for (int i = 0; i < 12; i++) reg_write(4'(i), 64'h0);
      // R7: window 0 direct, 1 MB, base bits 30:20 = 0x401
      reg_write(4'd0, 64'h0000_0000_4010_0001);
      reg_write(4'd8, 64'h0000_0012_3450_0000);
      xlate_check("R7 direct hit", 64'h0000_0000_4018_7654);
      // R4: bits above 30 ignored
      xlate_check("R4 high bits ignored", 64'hFFFF_FFFF_C018_7654);
      xlate_check("R4 field mismatch", 64'h0000_0000_4020_0000);
      // R7: mask opens bits 22:20, so they pass through from the bus address
      reg_write(4'd4, 64'h0000_0000_0070_0000);
      xlate_check("R7 masked field", 64'h0000_0000_4070_0ABC);
      // R5: disabled window skipped, window 1 catches it
      reg_write(4'd1, 64'h0000_0000_4000_0001);
      reg_write(4'd5, 64'h0000_0000_0070_0000);
      reg_write(4'd9, 64'h0000_0000_8000_0000);
      reg_write(4'd0, 64'h0000_0000_4010_0000);
      xlate_check("R5 disabled skip", 64'h0000_0000_4050_0123);
      // R8: window 0 enabled again wins over window 1
      reg_write(4'd0, 64'h0000_0000_4010_0001);
      xlate_check("R8 priority", 64'h0000_0000_4050_0123);
      // R6: scatter-gather on deciding window
      reg_write(4'd0, 64'h0000_0000_4010_0003);
      xlate_check("R6 sg error", 64'h0000_0000_4050_0123);
      // R11: write in the same cycle as the request
      model(64'h0000_0000_4050_0123, ea, eh, ee);
      @(negedge clk);
      req_valid = 1'b1; req_addr = 64'h0000_0000_4050_0123;
      reg_wr = 1'b1; reg_addr = 4'd0; reg_wdata = 64'h0;
      @(negedge clk);
      req_valid = 1'b0; reg_wr = 1'b0; m_reg[0] = 64'h0;
      check("R11 old values addr", rsp_addr, ea);
      check("R11 old values flags", {62'h0, rsp_hit, rsp_err}, {62'h0, eh, ee});
      xlate_check("R11 new values", 64'h0000_0000_4050_0123);
      // random mix
      for (int n = 0; n < 400; n++) begin
         int w = $urandom_range(0, 3);
         int k = $urandom_range(0, 3);
         if (k == 0) reg_write(4'(w), {$urandom, $urandom} & 64'hFFFF_FFFF_FFFF_FFF3
                                      | 64'($urandom_range(0, 3)));
         else if (k == 1) reg_write(4'(4 + w), {$urandom, $urandom} & (($urandom_range(0, 1) != 0) ? 64'h0 : 64'hFFFF_FFFF_FFFF_FFFF));
         else if (k == 2) reg_write(4'(8 + w), {$urandom, $urandom});
         a = ($urandom_range(0, 3) != 0) ? (m_reg[w] & 64'h7FF0_0000) | 64'($urandom_range(0, 20'hFFFFF))
                                           | ({32'($urandom), 32'h0} & 64'hFFFF_FFFF_0000_0000)
                                         : {$urandom, $urandom};
         xlate_check("R4/R5/R6/R7/R8/R9 random", a);
         if (n % 50 == 0) reg_check("R2/R3 random read", 4'($urandom_range(0, 15)));
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      fails++;
      $display("FAIL watchdog expired actual=hung expected=done");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule